// File: doc/BRIEF.md
# Serial Control Register Bank

This block is a write-only, three-line serial port with an active-low select. Through it a host loads the configuration of an audio conversion path. The host lowers the select line and shifts a 16-bit word in on a data line, one bit per rising edge of a control clock, most significant bit first. It then raises a latch line. If exactly sixteen bits have arrived, the rising latch edge commits the word. A 3-bit address field in the word picks one of five configuration registers, and the 9-bit data field is copied into that register. Every field of every register is driven straight out to the rest of the chip.

The serial lines are asynchronous to the system clock. They pass through a synchronizer whose depth is set by a parameter. Edges of the control clock and the latch line are found by sampling on the system clock, so the serial clock must run well below the system clock. The fifth register is guarded by a key. It accepts writes only after the key has been written into the upper data bits of the third register.

Top module: `sctl_top`

## Requirements
- R1: After reset the left and right attenuation fields read 8'hFF. Every other output field reads 0, and the guarded register is locked.
- R2: A word is 16 bits and is shifted in most significant bit first. Bits are sampled on rising control-clock edges while select is low. Word bits [11:9] are the address and bits [8:0] are the data. Bits [15:12] have no effect.
- R3: A word is committed only on a rising latch edge, and only when exactly 16 bits have been shifted since the count last restarted. A latch after 15 bits or after 17 bits changes no output.
- R4: The bit count restarts whenever select is high and after every latch edge. A latch edge while select is high commits nothing. A word that was broken off by raising select does not disturb the next complete word.
- R5: Address 000 loads data[7:0] into the left attenuation and data[8] into the left load flag. Address 001 does the same for the right channel.
- R6: Address 010 loads mute from data[0], de-emphasis enable from data[1], output disable from data[2] and word length from data[4:3].
- R7: Address 011 loads data[0] into the I2S-format flag and data[1] into the frame polarity flag. It also loads common attenuation from data[2], slow roll-off from data[3], phase reverse from data[4], clock-out divide from data[5], de-emphasis rate from data[7:6] and zero-detect enable from data[8].
- R8: A write to address 010 unlocks the guarded register when data[8:5] is 1111, and locks it otherwise. Address 110 loads data[5:4] into the differential mode and data[6] into clock-loss-detect disable, but only while the register is unlocked.
- R9: Writes to addresses 100, 101 and 111, and writes to address 110 while locked, leave every output field unchanged.
- R10: Output fields change only in the system-clock cycle after a commit. Shifting a full word without a latch changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| ctlClk | input | 1 | Serial control clock |
| ctlLatch | input | 1 | Serial latch; rising edge commits |
| ctlData | input | 1 | Serial data |
| attL | output | 8 | Left attenuation code |
| ldL | output | 1 | Left attenuation load flag |
| attR | output | 8 | Right attenuation code |
| ldR | output | 1 | Right attenuation load flag |
| mute | output | 1 | Soft mute request |
| demEn | output | 1 | De-emphasis enable |
| outDis | output | 1 | Force output to zero |
| wordLen | output | 2 | Input word length code |
| i2sFmt | output | 1 | I2S framing select |
| lrPol | output | 1 | Frame clock polarity |
| commonAtt | output | 1 | Use left attenuation for both channels |
| slowRoll | output | 1 | Slow roll-off filter select |
| phaseRev | output | 1 | Output phase reverse |
| clkOutDiv | output | 1 | Clock output divide select |
| demRate | output | 2 | De-emphasis rate code |
| zeroDetEn | output | 1 | Zero-detect mute enable |
| diffMode | output | 2 | Differential output mode |
| clkLossDis | output | 1 | Clock-loss detector disable |

## Verification
The hardest state to reach is the guarded register's lock. It is not visible at any port, and it can only be seen through whether an address-110 write takes effect. The stimulus first writes address 110 while locked and checks that nothing changes. It then writes the key through address 010, writes address 110 again and sees the new value. Finally it relocks with a keyless 010 write and shows that a further 110 write is dropped. A second hard case is the bit count at the instant the latch arrives. Words of 15 and 17 bits, a word broken off by select, and a latch given while select is high all bring it about.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_BITS = 16;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 9;
  localparam int ADDR_LSB  = DATA_W;

  typedef struct packed {
    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wrStrobe_t;

  localparam logic [ADDR_W-1:0] ADDR_ATT_L = 3'b000;
  localparam logic [ADDR_W-1:0] ADDR_ATT_R = 3'b001;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'b010;
  localparam logic [ADDR_W-1:0] ADDR_FMT   = 3'b011;
  localparam logic [ADDR_W-1:0] ADDR_GUARD = 3'b110;
  localparam logic [3:0]        UNLOCK_KEY = 4'b1111;
endpackage

// File: rtl/sctl_rx.sv
module sctl_rx
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       ctlClk,
  input  logic       ctlLatch,
  input  logic       ctlData,
  output wrStrobe_t  wrStb
);
  localparam int CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_BITS + 1);

  // lane order: {select, latch, clock, data}; select idles high
  logic [SYNC_STAGES-1:0][3:0] syncPipe;
  logic [3:0] syncOut;
  logic prevClk, prevLatch;
  logic clkRise, latchRise;
  logic [WORD_BITS-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= 4'b1000;
    end else begin
      syncPipe[0] <= {csN, ctlLatch, ctlClk, ctlData};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign syncOut   = syncPipe[SYNC_STAGES-1];
  assign clkRise   = syncOut[1] & ~prevClk;
  assign latchRise = syncOut[2] & ~prevLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk   <= 1'b0;
      prevLatch <= 1'b0;
      shiftReg  <= '0;
      bitCnt    <= '0;
    end else begin
      prevClk   <= syncOut[1];
      prevLatch <= syncOut[2];
      if (syncOut[3]) begin
        bitCnt <= '0;
      end else if (latchRise) begin
        bitCnt <= '0;
      end else if (clkRise) begin
        shiftReg <= {shiftReg[WORD_BITS-2:0], syncOut[0]};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    wrStb.commit = latchRise & ~syncOut[3] & (bitCnt == CNT_FULL);
    wrStb.addr   = shiftReg[ADDR_LSB +: ADDR_W];
    wrStb.data   = shiftReg[DATA_W-1:0];
  end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  wrStrobe_t  wrStb,
  output logic [7:0] attL,
  output logic       ldL,
  output logic [7:0] attR,
  output logic       ldR,
  output logic       mute,
  output logic       demEn,
  output logic       outDis,
  output logic [1:0] wordLen,
  output logic       i2sFmt,
  output logic       lrPol,
  output logic       commonAtt,
  output logic       slowRoll,
  output logic       phaseRev,
  output logic       clkOutDiv,
  output logic [1:0] demRate,
  output logic       zeroDetEn,
  output logic [1:0] diffMode,
  output logic       clkLossDis
);
  logic unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {ldL, attL} <= 9'h0FF;
      {ldR, attR} <= 9'h0FF;
      {wordLen, outDis, demEn, mute} <= '0;
      {zeroDetEn, demRate, clkOutDiv, phaseRev, slowRoll, commonAtt, lrPol, i2sFmt} <= '0;
      {clkLossDis, diffMode} <= '0;
      unlocked <= 1'b0;
    end else if (wrStb.commit) begin
      case (wrStb.addr)
        ADDR_ATT_L: {ldL, attL} <= wrStb.data;
        ADDR_ATT_R: {ldR, attR} <= wrStb.data;
        ADDR_CTRL: begin
          {wordLen, outDis, demEn, mute} <= wrStb.data[4:0];
          unlocked <= (wrStb.data[8:5] == UNLOCK_KEY);
        end
        ADDR_FMT:
          {zeroDetEn, demRate, clkOutDiv, phaseRev, slowRoll, commonAtt, lrPol, i2sFmt} <= wrStb.data;
        ADDR_GUARD:
          if (unlocked) {clkLossDis, diffMode} <= wrStb.data[6:4];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sctl_top.sv
module sctl_top
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       ctlClk,
  input  logic       ctlLatch,
  input  logic       ctlData,
  output logic [7:0] attL,
  output logic       ldL,
  output logic [7:0] attR,
  output logic       ldR,
  output logic       mute,
  output logic       demEn,
  output logic       outDis,
  output logic [1:0] wordLen,
  output logic       i2sFmt,
  output logic       lrPol,
  output logic       commonAtt,
  output logic       slowRoll,
  output logic       phaseRev,
  output logic       clkOutDiv,
  output logic [1:0] demRate,
  output logic       zeroDetEn,
  output logic [1:0] diffMode,
  output logic       clkLossDis
);
  wrStrobe_t wrStb;

  sctl_rx #(.SYNC_STAGES(SYNC_STAGES)) uRx (
    .clk(clk), .rstN(rstN), .csN(csN), .ctlClk(ctlClk),
    .ctlLatch(ctlLatch), .ctlData(ctlData), .wrStb(wrStb)
  );

  sctl_bank uBank (
    .clk(clk), .rstN(rstN), .wrStb(wrStb),
    .attL(attL), .ldL(ldL), .attR(attR), .ldR(ldR),
    .mute(mute), .demEn(demEn), .outDis(outDis), .wordLen(wordLen),
    .i2sFmt(i2sFmt), .lrPol(lrPol), .commonAtt(commonAtt), .slowRoll(slowRoll),
    .phaseRev(phaseRev), .clkOutDiv(clkOutDiv), .demRate(demRate),
    .zeroDetEn(zeroDetEn), .diffMode(diffMode), .clkLossDis(clkLossDis)
  );
endmodule

// File: rtl/sctl_chk.sv
module sctl_chk
  import sctl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input wrStrobe_t  wrStb,
  input logic [7:0] attL,
  input logic [7:0] attR,
  input logic       mute,
  input logic       zeroDetEn,
  input logic [1:0] diffMode,
  input logic       clkLossDis
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb.commit |=> ($stable(attL) && $stable(attR) && $stable(mute) &&
                       $stable(zeroDetEn) && $stable(diffMode) && $stable(clkLossDis)));

  p_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.commit |=> !wrStb.commit);

  p_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.commit && wrStb.addr == ADDR_ATT_L) |=> (attL == $past(wrStb.data[7:0])));

  p_mute_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.commit && wrStb.addr == ADDR_CTRL) |=> (mute == $past(wrStb.data[0])));

  p_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.commit && wrStb.addr == ADDR_FMT) |=> (zeroDetEn == $past(wrStb.data[8])));

  p_undef_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.commit && (wrStb.addr == 3'b100 || wrStb.addr == 3'b101 || wrStb.addr == 3'b111))
    |=> ($stable(attL) && $stable(attR) && $stable(diffMode) && $stable(clkLossDis)));
endmodule

bind sctl_top sctl_chk uChk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .attL(attL), .attR(attR),
  .mute(mute), .zeroDetEn(zeroDetEn), .diffMode(diffMode), .clkLossDis(clkLossDis)
);

// File: tb/tb_sctl_top.sv
module tb_sctl_top;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, ctlClk = 1'b0, ctlLatch = 1'b0, ctlData = 1'b0;
  logic [7:0] attL, attR;
  logic ldL, ldR, mute, demEn, outDis, i2sFmt, lrPol, commonAtt, slowRoll;
  logic phaseRev, clkOutDiv, zeroDetEn, clkLossDis;
  logic [1:0] wordLen, demRate, diffMode;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // expected register images
  logic [8:0] eM0, eM1, eM3;
  logic [4:0] eM2;
  logic [2:0] eM4;
  bit eUnlocked;

  always #2.5 clk = ~clk;

  sctl_top dut (
    .clk(clk), .rstN(rstN), .csN(csN), .ctlClk(ctlClk), .ctlLatch(ctlLatch),
    .ctlData(ctlData), .attL(attL), .ldL(ldL), .attR(attR), .ldR(ldR),
    .mute(mute), .demEn(demEn), .outDis(outDis), .wordLen(wordLen),
    .i2sFmt(i2sFmt), .lrPol(lrPol), .commonAtt(commonAtt), .slowRoll(slowRoll),
    .phaseRev(phaseRev), .clkOutDiv(clkOutDiv), .demRate(demRate),
    .zeroDetEn(zeroDetEn), .diffMode(diffMode), .clkLossDis(clkLossDis)
  );

  function automatic logic [34:0] snapDut();
    return {ldL, attL, ldR, attR, wordLen, outDis, demEn, mute,
            zeroDetEn, demRate, clkOutDiv, phaseRev, slowRoll, commonAtt, lrPol, i2sFmt,
            clkLossDis, diffMode};
  endfunction

  function automatic logic [34:0] snapExp();
    return {eM0, eM1, eM2, eM3, eM4};
  endfunction

  function automatic logic [15:0] mk(input logic [2:0] a, input logic [8:0] d);
    return {4'h0, a, d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [15:0] w);
    case (w[11:9])
      3'b000: eM0 = w[8:0];
      3'b001: eM1 = w[8:0];
      3'b010: begin eM2 = w[4:0]; eUnlocked = (w[8:5] == 4'b1111); end
      3'b011: eM3 = w[8:0];
      3'b110: if (eUnlocked) eM4 = w[6:4];
      default: ;
    endcase
  endtask

  task automatic shiftBits(input logic [15:0] w, input int n);
    csN = 1'b0;
    tick(HP);
    for (int i = 0; i < n; i++) begin
      ctlData = (i < 16) ? w[15-i] : 1'b0;
      ctlClk = 1'b0; tick(HP);
      ctlClk = 1'b1; tick(HP);
    end
    ctlClk = 1'b0; tick(HP);
  endtask

  task automatic pulseLatch();
    ctlLatch = 1'b1; tick(HP);
    ctlLatch = 1'b0; tick(HP);
  endtask

  task automatic endFrame();
    csN = 1'b1;
    tick(HP + 8);
  endtask

  task automatic sendWord(input logic [15:0] w);
    shiftBits(w, 16);
    pulseLatch();
    endFrame();
    modelWrite(w);
  endtask

  task automatic t_reset();
    check("R1 reset values", snapDut(), snapExp());
  endtask

  task automatic t_atten();
    sendWord(mk(3'b000, 9'h180));
    check("R5 left attenuation and load", snapDut(), snapExp());
    sendWord(mk(3'b001, 9'h001));
    check("R2 R5 right attenuation msb first", snapDut(), snapExp());
  endtask

  task automatic t_ctrl();
    sendWord(mk(3'b010, 9'h015));
    check("R6 control fields a", snapDut(), snapExp());
    sendWord(mk(3'b010, 9'h00A));
    check("R6 control fields b", snapDut(), snapExp());
  endtask

  task automatic t_fmt();
    sendWord(mk(3'b011, 9'h1A5));
    check("R7 format fields a", snapDut(), snapExp());
    sendWord(mk(3'b011, 9'h05A));
    check("R7 format fields b", snapDut(), snapExp());
  endtask

  task automatic t_upper();
    sendWord({4'hF, 3'b000, 9'h037});
    check("R2 upper bits ignored", snapDut(), snapExp());
  endtask

  task automatic t_noLatch();
    shiftBits(mk(3'b000, 9'h011), 16);
    check("R10 full word without latch", snapDut(), snapExp());
    endFrame();
  endtask

  task automatic t_count();
    shiftBits(mk(3'b001, 9'h0AA), 15);
    pulseLatch(); endFrame();
    check("R3 fifteen bits ignored", snapDut(), snapExp());
    shiftBits(mk(3'b001, 9'h055), 17);
    pulseLatch(); endFrame();
    check("R3 seventeen bits ignored", snapDut(), snapExp());
  endtask

  task automatic t_select();
    shiftBits(mk(3'b000, 9'h1FF), 8);
    endFrame();
    sendWord(mk(3'b000, 9'h0C3));
    check("R4 aborted word then full word", snapDut(), snapExp());
    shiftBits(mk(3'b000, 9'h012), 16);
    csN = 1'b1; tick(HP + 8);
    pulseLatch(); tick(8);
    check("R4 latch with select high ignored", snapDut(), snapExp());
  endtask

  task automatic t_guard();
    sendWord(mk(3'b110, 9'h070));
    check("R8 guarded write while locked", snapDut(), snapExp());
    sendWord(mk(3'b010, 9'h1E0));
    sendWord(mk(3'b110, 9'h050));
    check("R8 guarded write after key", snapDut(), snapExp());
    sendWord(mk(3'b010, 9'h0E0));
    sendWord(mk(3'b110, 9'h020));
    check("R8 relocked write dropped", snapDut(), snapExp());
  endtask

  task automatic t_undef();
    sendWord(mk(3'b100, 9'h1FF));
    sendWord(mk(3'b101, 9'h000));
    sendWord(mk(3'b111, 9'h155));
    check("R9 undefined addresses ignored", snapDut(), snapExp());
  endtask

  initial begin
    eM0 = 9'h0FF; eM1 = 9'h0FF; eM2 = '0; eM3 = '0; eM4 = '0; eUnlocked = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(5);
    t_reset();
    t_atten();
    t_ctrl();
    t_fmt();
    t_upper();
    t_noLatch();
    t_count();
    t_select();
    t_guard();
    t_undef();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule